// File: doc/BRIEF.md
# Configurable LUT Logic Slice

This block models one programmable logic slice: four 6-input lookup tables, a tree of wide-function multiplexers, and four flip-flops. Each 6-input table is two 32-entry halves that share the five low inputs. The slice can therefore act as four 6-input functions or as eight 5-input functions. The multiplexer tree can also merge two tables into a 7-input function, or all four tables into one 8-input function, with the bypass inputs serving as the extra selects.

All truth tables and per-position option bits sit in one serial configuration chain. The chain shifts one bit per clock while `cfgEn` is high, and it is loaded before normal use. Each of the four output positions picks a source (full table output, lower-half output, wide-mux result or its bypass input). The position then presents that source either directly or through its flip-flop. With the bypass source, the flip-flop works as a plain register.

Top module: `lutSlice`

## Requirements
- R1: The configuration chain shifts in `cfgData` on each rising clock edge while `cfgEn` is high. Its load order is the table of LUT 0, then LUTs 1, 2 and 3, each with entry 63 first. The four 3-bit option fields for positions 0..3 follow, each MSB first. After loading, `o6Out[i]` equals entry `lutIn[6i+5:6i]` of table i.
- R2: `o5Out[i]` equals entry `{0, lutIn[6i+4:6i]}` of table i (the lower half), regardless of `lutIn[6i+5]`.
- R3: `f7LoOut` is `o6Out[1]` when `bypIn[0]` is 1 and `o6Out[0]` otherwise. `f7HiOut` is `o6Out[3]` when `bypIn[2]` is 1 and `o6Out[2]` otherwise.
- R4: `f8Out` is `f7HiOut` when `bypIn[1]` is 1 and `f7LoOut` otherwise, giving one 8-input function.
- R5: Each option field is `{src[1:0], useReg}`. The src codes are 0 for the table output `o6Out[p]`, 1 for `o5Out[p]`, 2 for the wide result and 3 for `bypIn[p]`. The wide result is `f7LoOut` at position 0, `f8Out` at positions 1 and 3, and `f7HiOut` at position 2. With useReg=0, `yOut[p]` is the selected source, combinationally.
- R6: With `rst` and `cfgEn` low, `qOut[p]` captures the selected source at each rising edge. With useReg=1, `yOut[p]` equals `qOut[p]`. With src=3 this makes a standalone register of `bypIn[p]`.
- R7: A high `rst` at a rising edge clears all four flip-flops to 0 and leaves the configuration contents unchanged.
- R8: While `cfgEn` is high the flip-flops hold their value.
- R9: While `cfgEn` is low, `cfgData` has no effect on the stored configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration shifting and the slice flip-flops |
| rst | input | 1 | Synchronous active-high clear of the flip-flops |
| cfgEn | input | 1 | Configuration shift enable |
| cfgData | input | 1 | Serial configuration bit |
| lutIn | input | 24 | Table address inputs, LUT i at bits [6i+5:6i] |
| bypIn | input | 4 | Bypass inputs: wide-mux selects and standalone register data |
| o6Out | output | 4 | Full 6-input table outputs |
| o5Out | output | 4 | Lower-half 5-input table outputs |
| f7LoOut | output | 1 | 7-input result from LUTs 0 and 1 |
| f7HiOut | output | 1 | 7-input result from LUTs 2 and 3 |
| f8Out | output | 1 | 8-input result |
| qOut | output | 4 | Flip-flop contents |
| yOut | output | 4 | Position outputs, combinational or registered per option |

## Verification
Random truth tables are loaded and every 6-bit address is swept on all four tables at once. Each table gets a different address offset, so a swapped input slice or a reversed load order shows up as a mismatch in both the full and the lower-half outputs. A sweep over all 512 combinations of table address and the three select bypasses exercises the 7- and 8-input paths and tells apart an exchanged select or data leg. The output-select checks cover every source code in both combinational and registered modes, and further checks drive the flip-flops with shifting, reset and stray serial data to show what must and must not change.

// File: rtl/lutSlice_pkg.sv
package lutSlice_pkg;

  // number of table/flip-flop positions in the slice (the wide-mux tree is built for four)
  localparam int NPOS = 4;

  typedef enum logic [1:0] {
    SRC_O6   = 2'd0,
    SRC_O5   = 2'd1,
    SRC_WIDE = 2'd2,
    SRC_BYP  = 2'd3
  } srcSel_e;

  // one option field per output position, shifted in MSB first
  typedef struct packed {
    srcSel_e src;
    logic    useReg;
  } posOpt_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic ffClear;
    logic ffLoad;
  } sliceStrobe_t;

endpackage

// File: rtl/lutSliceCtrl.sv
module lutSliceCtrl
  import lutSlice_pkg::*;
(
  input  logic         rst,
  input  logic         cfgEn,
  output sliceStrobe_t stb
);

  always_comb begin
    stb.shiftEn = cfgEn;
    stb.ffClear = rst;
    stb.ffLoad  = !rst && !cfgEn;
  end

endmodule

// File: rtl/lutSliceLut6.sv
module lutSliceLut6 #(
  parameter int K5 = 5
) (
  input  logic [(2 << K5)-1:0] truth,
  input  logic [K5:0]          sel,
  output logic                 o6,
  output logic                 o5
);

  localparam int TT5 = 1 << K5;

  logic [1:0] half;

  // two equal-depth halves, each a fixed-depth select on the shared low inputs
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [TT5-1:0] tbl;
    assign tbl     = truth[h*TT5 +: TT5];
    assign half[h] = tbl[sel[K5-1:0]];
  end

  assign o5 = half[0];
  assign o6 = sel[K5] ? half[1] : half[0];

endmodule

// File: rtl/lutSliceDatapath.sv
module lutSliceDatapath
  import lutSlice_pkg::*;
#(
  parameter int K5 = 5
) (
  input  logic                     clk,
  input  sliceStrobe_t             stb,
  input  logic                     cfgData,
  input  logic [NPOS*(K5+1)-1:0]   lutIn,
  input  logic [NPOS-1:0]          bypIn,
  output logic [NPOS-1:0]          o6Out,
  output logic [NPOS-1:0]          o5Out,
  output logic                     f7LoOut,
  output logic                     f7HiOut,
  output logic                     f8Out,
  output logic [NPOS-1:0]          qOut,
  output logic [NPOS-1:0]          yOut
);

  localparam int K6    = K5 + 1;
  localparam int TT6   = 2 << K5;
  localparam int OPT_W = $bits(posOpt_t);
  localparam int TBL_W = NPOS * TT6;
  localparam int OPT_T = NPOS * OPT_W;
  localparam int CFG_W = TBL_W + OPT_T;

  // configuration storage: not touched by the slice reset
  logic [CFG_W-1:0] cfgChain;
  logic [NPOS-1:0]  dVal;

  always_ff @(posedge clk) begin
    if (stb.shiftEn) cfgChain <= {cfgChain[CFG_W-2:0], cfgData};
  end

  // tables: first-loaded table occupies the top of the chain
  for (genvar i = 0; i < NPOS; i++) begin : g_lut
    lutSliceLut6 #(.K5(K5)) u_lut (
      .truth (cfgChain[CFG_W-1-i*TT6 -: TT6]),
      .sel   (lutIn[i*K6 +: K6]),
      .o6    (o6Out[i]),
      .o5    (o5Out[i])
    );
  end

  // wide-function tree
  assign f7LoOut = bypIn[0] ? o6Out[1] : o6Out[0];
  assign f7HiOut = bypIn[2] ? o6Out[3] : o6Out[2];
  assign f8Out   = bypIn[1] ? f7HiOut  : f7LoOut;

  // per-position source select and output mode
  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    posOpt_t opt;
    logic    wide;
    logic    srcVal;

    assign opt = posOpt_t'(cfgChain[OPT_T-1-p*OPT_W -: OPT_W]);

    if (p == 0) begin : g_wLo
      assign wide = f7LoOut;
    end else if (p == 2) begin : g_wHi
      assign wide = f7HiOut;
    end else begin : g_w8
      assign wide = f8Out;
    end

    always_comb begin
      case (opt.src)
        SRC_O6:   srcVal = o6Out[p];
        SRC_O5:   srcVal = o5Out[p];
        SRC_WIDE: srcVal = wide;
        default:  srcVal = bypIn[p];
      endcase
    end

    assign dVal[p] = srcVal;
    assign yOut[p] = opt.useReg ? qOut[p] : srcVal;
  end

  always_ff @(posedge clk) begin
    if (stb.ffClear)     qOut <= '0;
    else if (stb.ffLoad) qOut <= dVal;
  end

endmodule

// File: rtl/lutSlice.sv
module lutSlice
  import lutSlice_pkg::*;
#(
  parameter int K5 = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfgEn,
  input  logic                   cfgData,
  input  logic [NPOS*(K5+1)-1:0] lutIn,
  input  logic [NPOS-1:0]        bypIn,
  output logic [NPOS-1:0]        o6Out,
  output logic [NPOS-1:0]        o5Out,
  output logic                   f7LoOut,
  output logic                   f7HiOut,
  output logic                   f8Out,
  output logic [NPOS-1:0]        qOut,
  output logic [NPOS-1:0]        yOut
);

  sliceStrobe_t stb;

  lutSliceCtrl u_ctrl (
    .rst   (rst),
    .cfgEn (cfgEn),
    .stb   (stb)
  );

  lutSliceDatapath #(.K5(K5)) u_dp (
    .clk     (clk),
    .stb     (stb),
    .cfgData (cfgData),
    .lutIn   (lutIn),
    .bypIn   (bypIn),
    .o6Out   (o6Out),
    .o5Out   (o5Out),
    .f7LoOut (f7LoOut),
    .f7HiOut (f7HiOut),
    .f8Out   (f8Out),
    .qOut    (qOut),
    .yOut    (yOut)
  );

endmodule

// File: rtl/lutSlice_chk.sv
module lutSlice_chk
  import lutSlice_pkg::*;
#(
  parameter int K5 = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfgEn,
  input logic [NPOS*(K5+1)-1:0] lutIn,
  input logic [NPOS-1:0]        o6Out,
  input logic [NPOS-1:0]        o5Out,
  input logic                   f7LoOut,
  input logic                   f7HiOut,
  input logic                   f8Out,
  input logic [NPOS-1:0]        qOut
);

  localparam int K6 = K5 + 1;

  logic [NPOS-1:0] lowHalf;
  always_comb begin
    for (int i = 0; i < NPOS; i++) lowHalf[i] = !lutIn[i*K6 + K5];
  end

  // R2: with the top address bit low, full and half outputs agree
  p_half_match_r2: assert property (@(posedge clk) disable iff (rst)
    ((o5Out ^ o6Out) & lowHalf) == '0);

  // R3: when both table legs agree the 7-input result must match them
  p_f7lo_agree_r3: assert property (@(posedge clk) disable iff (rst)
    (o6Out[0] == o6Out[1]) |-> (f7LoOut == o6Out[0]));
  p_f7hi_agree_r3: assert property (@(posedge clk) disable iff (rst)
    (o6Out[2] == o6Out[3]) |-> (f7HiOut == o6Out[2]));

  // R4: when both 7-input results agree the 8-input result must match
  p_f8_agree_r4: assert property (@(posedge clk) disable iff (rst)
    (f7LoOut == f7HiOut) |-> (f8Out == f7LoOut));

  // R7: a reset edge leaves every flip-flop at zero
  p_rst_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (qOut == '0));

  // R8: flip-flops hold across a shifting cycle
  p_ff_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfgEn)) |-> $stable(qOut));

  // R9: no shift means unchanged tables for unchanged addresses
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfgEn) && $stable(lutIn)) |-> ($stable(o6Out) && $stable(o5Out)));

endmodule

bind lutSlice lutSlice_chk #(.K5(K5)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfgEn   (cfgEn),
  .lutIn   (lutIn),
  .o6Out   (o6Out),
  .o5Out   (o5Out),
  .f7LoOut (f7LoOut),
  .f7HiOut (f7HiOut),
  .f8Out   (f8Out),
  .qOut    (qOut)
);

// File: tb/lutSlice_tb.sv
`timescale 1ns/1ps
module lutSlice_tb;

  logic        clk = 0;
  logic        rst = 1;
  logic        cfgEn = 0;
  logic        cfgData = 0;
  logic [23:0] lutIn = '0;
  logic [3:0]  bypIn = '0;
  logic [3:0]  o6Out, o5Out, qOut, yOut;
  logic        f7LoOut, f7HiOut, f8Out;

  int checks = 0;
  int errors = 0;

  logic [63:0] tt [4];
  logic [2:0]  opt [4];   // {src[1:0], useReg}

  always #5 clk = ~clk;

  lutSlice u_dut (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgData(cfgData),
    .lutIn(lutIn), .bypIn(bypIn),
    .o6Out(o6Out), .o5Out(o5Out), .f7LoOut(f7LoOut), .f7HiOut(f7HiOut),
    .f8Out(f8Out), .qOut(qOut), .yOut(yOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int idxOf(int i, int base);
    return (base + i * 17) % 64;
  endfunction

  function automatic logic [3:0] refO6(int base);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = tt[i][idxOf(i, base)];
    return r;
  endfunction

  function automatic logic [3:0] refO5(int base);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = tt[i][idxOf(i, base) & 31];
    return r;
  endfunction

  function automatic logic refF7Lo(int base, logic [3:0] byp);
    logic [3:0] o = refO6(base);
    return byp[0] ? o[1] : o[0];
  endfunction

  function automatic logic refF7Hi(int base, logic [3:0] byp);
    logic [3:0] o = refO6(base);
    return byp[2] ? o[3] : o[2];
  endfunction

  function automatic logic refF8(int base, logic [3:0] byp);
    return byp[1] ? refF7Hi(base, byp) : refF7Lo(base, byp);
  endfunction

  function automatic logic [3:0] refSrc(int base, logic [3:0] byp);
    logic [3:0] r;
    logic [3:0] o6 = refO6(base);
    logic [3:0] o5 = refO5(base);
    for (int p = 0; p < 4; p++) begin
      case (opt[p][2:1])
        2'd0: r[p] = o6[p];
        2'd1: r[p] = o5[p];
        2'd2: r[p] = (p == 0) ? refF7Lo(base, byp) :
                     (p == 2) ? refF7Hi(base, byp) : refF8(base, byp);
        default: r[p] = byp[p];
      endcase
    end
    return r;
  endfunction

  task automatic setIn(int base, logic [3:0] byp);
    for (int i = 0; i < 4; i++) lutIn[i*6 +: 6] = 6'(idxOf(i, base));
    bypIn = byp;
  endtask

  task automatic shiftBit(logic v);
    @(negedge clk);
    cfgEn   = 1;
    cfgData = v;
  endtask

  task automatic loadCfg();
    for (int l = 0; l < 4; l++)
      for (int b = 63; b >= 0; b--) shiftBit(tt[l][b]);
    for (int p = 0; p < 4; p++)
      for (int b = 2; b >= 0; b--) shiftBit(opt[p][b]);
    @(negedge clk);
    cfgEn   = 0;
    cfgData = 0;
  endtask

  task automatic newTables();
    for (int l = 0; l < 4; l++) tt[l] = {$urandom(), $urandom()};
  endtask

  // R1 R7: load during reset, flip-flops read zero afterwards
  task automatic testReset();
    newTables();
    for (int p = 0; p < 4; p++) opt[p] = 3'b000;
    loadCfg();
    @(posedge clk); #1;
    check("R7 reset state qOut", 32'(qOut), 32'h0);
    @(negedge clk);
    rst = 0;
  endtask

  // R1 R2: every address on all four tables
  task automatic testLutSweep(string tag);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      setIn(a, 4'h0);
      #1;
      check({tag, " R1 o6Out"}, 32'(o6Out), 32'(refO6(a)));
      check({tag, " R2 o5Out"}, 32'(o5Out), 32'(refO5(a)));
    end
  endtask

  // R3 R4: all address and select combinations
  task automatic testWide();
    for (int k = 0; k < 512; k++) begin
      logic [3:0] byp;
      byp = {1'b0, k[8], k[7], k[6]};
      @(negedge clk);
      setIn(k & 63, byp);
      #1;
      check("R3 f7LoOut", 32'(f7LoOut), 32'(refF7Lo(k & 63, byp)));
      check("R3 f7HiOut", 32'(f7HiOut), 32'(refF7Hi(k & 63, byp)));
      check("R4 f8Out",   32'(f8Out),   32'(refF8(k & 63, byp)));
    end
  endtask

  // R5: every source code, combinational mode
  task automatic testCombSelect();
    newTables();
    opt[0] = 3'b000; opt[1] = 3'b010; opt[2] = 3'b100; opt[3] = 3'b110;
    loadCfg();
    for (int n = 0; n < 40; n++) begin
      int base = $urandom_range(63);
      logic [3:0] byp = 4'($urandom());
      @(negedge clk);
      setIn(base, byp);
      #1;
      check("R5 comb yOut", 32'(yOut), 32'(refSrc(base, byp)));
    end
    opt[0] = 3'b110; opt[1] = 3'b100; opt[2] = 3'b010; opt[3] = 3'b100;
    loadCfg();
    for (int n = 0; n < 40; n++) begin
      int base = $urandom_range(63);
      logic [3:0] byp = 4'($urandom());
      @(negedge clk);
      setIn(base, byp);
      #1;
      check("R5 comb yOut alt", 32'(yOut), 32'(refSrc(base, byp)));
    end
  endtask

  // R6: registered mode captures the selected source
  task automatic testRegSelect();
    opt[0] = 3'b101; opt[1] = 3'b111; opt[2] = 3'b001; opt[3] = 3'b011;
    loadCfg();
    for (int n = 0; n < 40; n++) begin
      int base = $urandom_range(63);
      logic [3:0] byp = 4'($urandom());
      logic [3:0] exp;
      @(negedge clk);
      setIn(base, byp);
      exp = refSrc(base, byp);
      @(posedge clk); #1;
      check("R6 qOut", 32'(qOut), 32'(exp));
      check("R6 yOut registered", 32'(yOut), 32'(exp));
    end
  endtask

  // R8: shifting freezes the flip-flops
  task automatic testCfgHoldsFf();
    logic [3:0] keep = qOut;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      cfgEn   = 1;
      cfgData = 1'($urandom());
      setIn($urandom_range(63), ~keep);
      @(posedge clk); #1;
      check("R8 qOut held while shifting", 32'(qOut), 32'(keep));
    end
    @(negedge clk);
    cfgEn = 0;
  endtask

  // R6 R7: standalone registers, then reset keeps tables
  task automatic testResetKeepsCfg();
    newTables();
    for (int p = 0; p < 4; p++) opt[p] = 3'b111;
    loadCfg();
    @(negedge clk);
    bypIn = 4'hA;
    @(posedge clk); #1;
    check("R6 standalone qOut", 32'(qOut), 32'hA);
    @(negedge clk);
    bypIn = 4'hF;
    @(posedge clk); #1;
    check("R6 standalone yOut", 32'(yOut), 32'hF);
    @(negedge clk);
    rst = 1;
    @(posedge clk); #1;
    check("R7 reset clears qOut", 32'(qOut), 32'h0);
    @(negedge clk);
    rst = 0;
    testLutSweep("R7 config kept");
  endtask

  // R9: serial data ignored without enable
  task automatic testCfgIgnored();
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      cfgEn   = 0;
      cfgData = 1'($urandom());
    end
    testLutSweep("R9 stray data");
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testLutSweep("base");
    testWide();
    testCombSelect();
    testRegSelect();
    testCfgHoldsFf();
    testResetKeepsCfg();
    testCfgIgnored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule